// File: doc/BRIEF.md
# SPI Register Command Engine

This block sits on the device side of an SPI link, after a word-level shift stage. It reads 32-bit words from the host (the MOSI stream) and returns one 32-bit word per accepted word (the MISO stream). Each command starts with a control header. The header selects read or write, a register space, a start address and a burst length. The block then performs the accesses on an internal register file.

Write commands store the data words that follow the header. Read commands return register contents. In both cases the address steps up by one after each access. The reply runs one word behind the host. A command's first MISO word is zero, its second is the echoed header, and after that come the echoed write data or the read values. The host marks each command by holding `frame_active` high for its whole length. When `frame_active` drops, the parser returns to waiting for a header.

Both word streams use valid/ready handshakes. A MOSI word transfers on a cycle where `mosi_valid` and `mosi_ready` are both high. `mosi_ready` is high only while `frame_active` is high and the single MISO output slot is empty or is being emptied in that cycle. A MISO word transfers on `miso_valid` and `miso_ready`. While `miso_ready` is low, a pending MISO word keeps its value. Back-pressure on MISO stalls MOSI intake directly.

Top module: `spi_ctl_regs`

## Requirements
- R1: Header fields, by bit position:
  - bit 31: data flag (0 for a control command)
  - bit 29: write flag (1 = write)
  - bits 27:24: register-space selector
  - bits 23:8: start address
  - bits 7:1: length minus one
  - bit 0: parity, set so that the whole header has an odd number of ones

  For each accepted MOSI word, exactly one MISO word is produced. That MISO word carries the response to the previously accepted MOSI word of the same frame; for the first word of a frame it is zero. So a command's MISO words are: zero, then the echoed header.
- R2: A write with length L stores the L data words that follow the header, at the start address and the L−1 addresses after it. The address is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R3: In a write, each data word is echoed on MISO one word after it is received.
- R4: The host sends one extra word after the last data word of a write. That word is never stored.
- R5: A read with length L returns, on MISO words 2 to L+1, the registers from the start address upward, with the same 16-bit wrap. Host data sent during a read has no effect.
- R6: The register file answers only to selector 0. Within that space, only addresses below 8 that have their bit set in the implemented mask 0xF7 exist, so address 3 is a hole. Reading any other address returns zero, and writing to it has no effect.
- R7: A control header with even parity causes no register access in the rest of its frame and sets `hdr_err`. The header is still echoed, and all later MISO words of that frame are zero. The next control header with correct parity clears `hdr_err`.
- R8: A header with the data flag set causes no access, and every MISO word of its frame is zero. It leaves `hdr_err` unchanged.
- R9: Handshake rules: `mosi_ready` is low while `frame_active` is low, and also while an untaken MISO word is stalled. A stalled MISO word stays valid and unchanged. After reset, `miso_valid`, `mosi_ready` and `hdr_err` are low.
- R10: When `frame_active` drops, an unfinished command is abandoned. Accesses already made are kept, and the next word accepted is parsed as a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_active | input | 1 | High for the duration of one command |
| mosi_valid | input | 1 | Host word available |
| mosi_data | input | 32 | Host word |
| mosi_ready | output | 1 | Block accepts the host word |
| miso_valid | output | 1 | Reply word available |
| miso_data | output | 32 | Reply word |
| miso_ready | input | 1 | Shift stage takes the reply word |
| hdr_err | output | 1 | Last control header had a parity error |

## Verification
Two things can happen in the same cycle: a register write, and the hand-off of the previous word's echo on MISO. A stall on `miso_ready` in that cycle must hold back the next data word without losing or repeating a write. The bench creates this overlap by lowering `miso_ready` one cycle in three while full-length write bursts run. It then judges the result from the echo order in the scoreboard and from a read-back of every address touched, including the holes and the address after each burst.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int CMD_W  = 32;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 7;
  localparam int SEL_W  = 4;

  typedef struct packed {
    logic             is_data;
    logic             rsv_a;
    logic             write;
    logic             rsv_b;
    logic [SEL_W-1:0] sel;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0] len_m1;
    logic             par;
  } ctl_hdr_t;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_BODY = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_hdr_decode.sv
module spi_hdr_decode
  import spi_ctl_pkg::*;
(
  input  logic [CMD_W-1:0]  word,
  output logic              is_data,
  output logic              is_write,
  output logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len_m1,
  output logic              par_ok
);
  ctl_hdr_t hdr;

  assign hdr      = ctl_hdr_t'(word);
  assign is_data  = hdr.is_data;
  assign is_write = hdr.write;
  assign sel      = hdr.sel;
  assign addr     = hdr.addr;
  assign len_m1   = hdr.len_m1;
  // odd number of ones over the whole header means good parity
  assign par_ok   = ^word;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_ctl_pkg::*;
#(
  parameter int               NREGS     = 8,
  parameter logic [NREGS-1:0] IMPL_MASK = 8'hF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CMD_W-1:0]  rdata
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0][CMD_W-1:0] rd_vec;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (IMPL_MASK[i]) begin : g_impl
      logic [CMD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (we && (waddr == ADDR_W'(i))) begin
          q <= wdata;
        end
      end
      assign rd_vec[i] = q;
    end else begin : g_hole
      assign rd_vec[i] = '0;
    end
  end

  assign rdata = ({16'b0, raddr} < 32'(NREGS)) ? rd_vec[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_ctl_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              mosi_valid,
  input  logic [CMD_W-1:0]  mosi_data,
  output logic              mosi_ready,
  output logic              miso_valid,
  output logic [CMD_W-1:0]  miso_data,
  input  logic              miso_ready,
  input  logic              h_is_data,
  input  logic              h_write,
  input  logic [SEL_W-1:0]  h_sel,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [LEN_W-1:0]  h_len_m1,
  input  logic              h_par_ok,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CMD_W-1:0]  bus_wdata,
  input  logic [CMD_W-1:0]  bus_rdata,
  output logic              hdr_err
);
  phase_t            phase_q;
  logic              wr_q;
  logic              sel_ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [CMD_W-1:0]  prev_q;
  logic [CMD_W-1:0]  out_q;
  logic              out_vld_q;
  logic              err_q;
  logic [CMD_W-1:0]  resp_next;
  logic              accept;

  assign mosi_ready = frame_active && (!out_vld_q || miso_ready);
  assign accept     = mosi_valid && mosi_ready;
  assign miso_valid = out_vld_q;
  assign miso_data  = out_q;
  assign hdr_err    = err_q;

  assign bus_we    = accept && (phase_q == PH_BODY) && wr_q && sel_ok_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = mosi_data;

  // response to the word accepted now; it leaves one word later
  always_comb begin
    unique case (phase_q)
      PH_HDR:  resp_next = h_is_data ? '0 : mosi_data;
      PH_BODY: resp_next = wr_q ? mosi_data : (sel_ok_q ? bus_rdata : '0);
      default: resp_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_HDR;
      wr_q      <= 1'b0;
      sel_ok_q  <= 1'b0;
      addr_q    <= '0;
      remain_q  <= '0;
      prev_q    <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (out_vld_q && miso_ready) begin
        out_vld_q <= 1'b0;
      end
      if (!frame_active) begin
        phase_q <= PH_HDR;
        prev_q  <= '0;
      end else if (accept) begin
        out_vld_q <= 1'b1;
        out_q     <= prev_q;
        prev_q    <= resp_next;
        unique case (phase_q)
          PH_HDR: begin
            if (h_is_data) begin
              phase_q <= PH_DONE;
            end else if (!h_par_ok) begin
              err_q   <= 1'b1;
              phase_q <= PH_DONE;
            end else begin
              err_q    <= 1'b0;
              wr_q     <= h_write;
              sel_ok_q <= (h_sel == SEL_ID);
              addr_q   <= h_addr;
              remain_q <= h_len_m1;
              phase_q  <= PH_BODY;
            end
          end
          PH_BODY: begin
            addr_q <= addr_q + 1'b1;
            if (remain_q == '0) begin
              phase_q <= PH_DONE;
            end else begin
              remain_q <= remain_q - 1'b1;
            end
          end
          default: phase_q <= PH_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
#(
  parameter int               NREGS     = 8,
  parameter logic [NREGS-1:0] IMPL_MASK = 8'hF7,
  parameter logic [3:0]       SEL_ID    = 4'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_active,
  input  logic        mosi_valid,
  input  logic [31:0] mosi_data,
  output logic        mosi_ready,
  output logic        miso_valid,
  output logic [31:0] miso_data,
  input  logic        miso_ready,
  output logic        hdr_err
);
  logic              h_is_data;
  logic              h_write;
  logic [SEL_W-1:0]  h_sel;
  logic [ADDR_W-1:0] h_addr;
  logic [LEN_W-1:0]  h_len_m1;
  logic              h_par_ok;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [CMD_W-1:0]  bus_wdata;
  logic [CMD_W-1:0]  bus_rdata;

  spi_hdr_decode u_dec (
    .word     (mosi_data),
    .is_data  (h_is_data),
    .is_write (h_write),
    .sel      (h_sel),
    .addr     (h_addr),
    .len_m1   (h_len_m1),
    .par_ok   (h_par_ok)
  );

  spi_cmd_engine #(.SEL_ID(SEL_ID)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .mosi_valid   (mosi_valid),
    .mosi_data    (mosi_data),
    .mosi_ready   (mosi_ready),
    .miso_valid   (miso_valid),
    .miso_data    (miso_data),
    .miso_ready   (miso_ready),
    .h_is_data    (h_is_data),
    .h_write      (h_write),
    .h_sel        (h_sel),
    .h_addr       (h_addr),
    .h_len_m1     (h_len_m1),
    .h_par_ok     (h_par_ok),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .hdr_err      (hdr_err)
  );

  spi_reg_file #(.NREGS(NREGS), .IMPL_MASK(IMPL_MASK)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .waddr (bus_addr),
    .wdata (bus_wdata),
    .raddr (bus_addr),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/spi_ctl_regs_chk.sv
module spi_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_active,
  input logic        mosi_valid,
  input logic        mosi_ready,
  input logic        miso_valid,
  input logic [31:0] miso_data,
  input logic        miso_ready,
  input logic        hdr_err,
  input logic        bus_we
);
  // R9
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !mosi_ready);

  // R9
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_valid && !miso_ready) |=> (miso_valid && $stable(miso_data)));

  // R1
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi_valid && mosi_ready) |=> miso_valid);

  // R7
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !bus_we);

  // R10
  write_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> frame_active);
endmodule

bind spi_ctl_regs spi_ctl_regs_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_active (frame_active),
  .mosi_valid   (mosi_valid),
  .mosi_ready   (mosi_ready),
  .miso_valid   (miso_valid),
  .miso_data    (miso_data),
  .miso_ready   (miso_ready),
  .hdr_err      (hdr_err),
  .bus_we       (bus_we)
);

// File: tb/test_spi_ctl_regs.sv
`timescale 1ns/1ps
module test_spi_ctl_regs;
  localparam int        NREGS = 8;
  localparam logic [7:0] IMPL = 8'hF7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_active = 1'b0;
  logic        mosi_valid = 1'b0;
  logic [31:0] mosi_data = '0;
  logic        mosi_ready;
  logic        miso_valid;
  logic [31:0] miso_data;
  logic        miso_ready = 1'b1;
  logic        hdr_err;

  always #2 clk = ~clk;

  spi_ctl_regs i_spi_ctl_regs (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
    .mosi_valid(mosi_valid), .mosi_data(mosi_data), .mosi_ready(mosi_ready),
    .miso_valid(miso_valid), .miso_data(miso_data), .miso_ready(miso_ready),
    .hdr_err(hdr_err)
  );

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  bit          stall_en = 1'b0;
  int          cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mdl [0:NREGS-1];
  logic [31:0] dbuf [0:15];
  logic [31:0] mon_e;
  string       mon_t;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1 miso_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
  end

  // scoreboard monitor: a transfer is due at the next rising edge
  always @(negedge clk) begin
    if (rst_n && miso_valid && miso_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R1: actual extra MISO word %h expected none", miso_data);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, miso_data, mon_e);
      end
    end
  end

  function automatic bit exists(int a, logic [3:0] sel);
    return (sel == 4'd0) && (a < NREGS) && IMPL[a];
  endfunction

  function automatic logic [31:0] mk_hdr(bit dnc, bit wr, logic [3:0] sel,
                                         logic [15:0] addr, int len, bit bad);
    logic [31:0] h;
    h = {dnc, 1'b0, wr, 1'b0, sel, addr, 7'(len - 1), 1'b0};
    h[0] = ~^h[31:1];
    if (bad) h[0] = ~h[0];
    return h;
  endfunction

  task automatic push(logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic send_word(logic [31:0] w);
    mosi_valid = 1'b1;
    mosi_data  = w;
    do @(negedge clk); while (!mosi_ready);
    @(posedge clk);
    #1 mosi_valid = 1'b0;
  endtask

  task automatic frame_begin();
    @(posedge clk);
    #1 frame_active = 1'b1;
  endtask

  task automatic frame_end();
    @(posedge clk);
    #1 frame_active = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic run_cmd(bit dnc, bit wr, logic [3:0] sel, logic [15:0] addr,
                         int len, bit bad, string tg);
    logic [31:0] h;
    bit ok;
    h  = mk_hdr(dnc, wr, sel, addr, len, bad);
    ok = !dnc && !bad;
    frame_begin();
    push(32'h0, "R1 lag slot");
    push(dnc ? 32'h0 : h, dnc ? "R8 data header reply" : (bad ? "R7 header echo" : "R1 header echo"));
    send_word(h);
    for (int j = 0; j < len; j++) begin
      int a;
      a = int'(16'(addr + 16'(j)));
      if (!ok) begin
        push(32'h0, dnc ? "R8 suppressed reply" : "R7 suppressed reply");
      end else if (wr) begin
        push(dbuf[j], "R3 write echo");
        if (exists(a, sel)) mdl[a] = dbuf[j];
      end else begin
        push(exists(a, sel) ? mdl[a] : 32'h0, tg);
      end
      send_word(wr ? dbuf[j] : (32'hBAD0_0000 | 32'(j)));
    end
    send_word(32'hFEED_0000 | 32'(addr) + 32'(len));
    frame_end();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset miso_valid", {31'b0, miso_valid}, 32'h0);
    check("R9 reset mosi_ready", {31'b0, mosi_ready}, 32'h0);
    check("R9 reset hdr_err", {31'b0, hdr_err}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R9 ready low outside frame", {31'b0, mosi_ready}, 32'h0);

    // R2 R3 R4: two-word write, tail must not land at address 6
    dbuf[0] = 32'hA5A5_0004; dbuf[1] = 32'h5A5A_0005;
    run_cmd(0, 1, 4'd0, 16'd4, 2, 0, "");
    run_cmd(0, 0, 4'd0, 16'd4, 3, 0, "R2 R4 burst readback");

    // R6 full-space write across the hole at 3, under MISO stalls (R9)
    stall_en = 1'b1;
    for (int j = 0; j < 8; j++) dbuf[j] = 32'h1000_0000 + 32'(j * 32'h0101);
    run_cmd(0, 1, 4'd0, 16'd0, 8, 0, "");
    run_cmd(0, 0, 4'd0, 16'd0, 10, 0, "R5 R6 read across holes");
    run_cmd(0, 0, 4'd0, 16'd0, 8, 0, "R5 read data ignored");
    stall_en = 1'b0;

    // R6 other selector: reads zero, writes dropped
    run_cmd(0, 0, 4'd1, 16'd0, 2, 0, "R6 foreign selector read");
    dbuf[0] = 32'hDEAD_BEEF;
    run_cmd(0, 1, 4'd1, 16'd0, 1, 0, "");
    run_cmd(0, 0, 4'd0, 16'd0, 1, 0, "R6 foreign write dropped");

    // R7 parity error
    dbuf[0] = 32'hCAFE_0001;
    run_cmd(0, 1, 4'd0, 16'd1, 1, 1, "");
    check("R7 hdr_err set", {31'b0, hdr_err}, 32'h1);
    run_cmd(0, 0, 4'd0, 16'd1, 1, 0, "R7 no write on parity error");
    check("R7 hdr_err cleared", {31'b0, hdr_err}, 32'h0);

    // R8 data-flag header
    dbuf[0] = 32'hCAFE_0002;
    run_cmd(1, 1, 4'd0, 16'd2, 1, 0, "");
    run_cmd(0, 0, 4'd0, 16'd2, 1, 0, "R8 no write from data header");

    // R10 abandoned write: first data word kept, rest never written
    frame_begin();
    push(32'h0, "R10 lag slot");
    push(mk_hdr(0, 1, 4'd0, 16'd5, 4, 0), "R10 header echo");
    send_word(mk_hdr(0, 1, 4'd0, 16'd5, 4, 0));
    send_word(32'h7777_0005);
    mdl[5] = 32'h7777_0005;
    frame_end();
    run_cmd(0, 0, 4'd0, 16'd5, 2, 0, "R10 abandoned burst readback");

    // R2 address wrap: 0xFFFF is a hole, next access lands on 0
    dbuf[0] = 32'h0BAD_FFFF; dbuf[1] = 32'h600D_0000;
    run_cmd(0, 1, 4'd0, 16'hFFFF, 2, 0, "");
    run_cmd(0, 0, 4'd0, 16'hFFFF, 2, 0, "R2 R5 wrap readback");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule